// File: doc/BRIEF.md
# Twin-Predicated Move Sequencer

This block turns one register move into a stream of element moves. The source and the destination each have their own vector flag and their own predicate mask. Each emitted move is a pair of register numbers: the register to read and the register to write. A vector operand walks forward through its elements and skips every element whose mask bit is clear. A scalar operand stays on its base register.

The sequence stops as soon as either side runs out of elements. The same block therefore covers several kinds of move, chosen only by the flags and the masks:

- broadcast of a scalar, with or without a destination predicate;
- pulling one element out of a vector;
- a straight copy;
- a gather, a scatter, or both together.

The issue stage presents the already-redirected base register numbers, the flags, the masks and the vector length, then pulses `start`. The block then hands out moves over a valid/ready handshake, at most one per cycle. It pulses `done` when the sequence ends.

Top module: `twin_pred_mover`

## Requirements
- R1: `start` is taken only while `busy` is low. From the next cycle, `busy` stays high until the cycle after `done`. A `start`, or a change of any configuration input, while `busy` is high has no effect on the move stream.
- R2: Before each move, a vector source advances its element index to the lowest index at or above its current index whose source mask bit is set. Mask bit k belongs to element k, and bit 0 is element 0. A scalar source keeps index 0.
- R3: A vector destination advances its index in the same way, using the destination mask. A scalar destination keeps index 0.
- R4: Each move presents `mv_src` = (`src_base` + source index) mod NREG and `mv_dst` = (`dst_base` + destination index) mod NREG.
- R5: After each accepted move, the index of every vector operand becomes the index just used plus one.
- R6: If, after skipping, either index is at or above the vector length, the sequence ends. No move is emitted for that step, and `done` is high for exactly one cycle. A vector length of 0 emits no move.
- R7: With both operands scalar and a vector length of at least 1, exactly one move is emitted, followed by `done`.
- R8: An operand whose predicate enable is low behaves as if its mask were all ones, whatever its mask input holds.
- R9: While `mv_valid` is high and `mv_ready` is low, `mv_valid`, `mv_src` and `mv_dst` hold their values. A move counts only in a cycle where both are high.
- R10: A vector length above MAXVL is treated as MAXVL.
- R11: During and right after reset, `busy`, `mv_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken while idle) |
| src_base | input | IDX_W | Redirected source base register |
| dst_base | input | IDX_W | Redirected destination base register |
| src_vec | input | 1 | Source is a vector |
| dst_vec | input | 1 | Destination is a vector |
| src_pred_en | input | 1 | Apply the source mask |
| dst_pred_en | input | 1 | Apply the destination mask |
| src_mask | input | MAXVL | Source predicate, bit k for element k |
| dst_mask | input | MAXVL | Destination predicate, bit k for element k |
| vl | input | VL_W | Vector length |
| busy | output | 1 | Sequence in progress |
| mv_valid | output | 1 | A move is presented |
| mv_ready | input | 1 | Consumer takes the presented move |
| mv_src | output | IDX_W | Register to read |
| mv_dst | output | IDX_W | Register to write |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench builds the block with NREG = 16 and MAXVL = 8. A 16-entry register space lets a short copy starting near the top wrap past register 15 in four moves. The 4-bit length field can carry 12, which is above MAXVL, so the clamp is exercised. Eight-bit masks keep every skip pattern small enough to write by hand: sparse broadcast, extraction, gather, scatter, combined gather and scatter, masks set only beyond the length, and an empty mask. Every table case is repeated under a ready pattern that stalls one cycle in three, so each presented pair is also checked for holding during a stall.

// File: rtl/pmv_pkg.sv
package pmv_pkg;
  typedef enum logic {
    PMV_IDLE = 1'b0,
    PMV_RUN  = 1'b1
  } pmv_state_e;
endpackage

// File: rtl/pmv_lane.sv
// One operand side: holds the element index and finds the next enabled element.
module pmv_lane #(
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cfg_vec,
  input  logic [MAXVL-1:0] cfg_mask,
  input  logic [IDX_W-1:0] cfg_base,
  input  logic [VL_W-1:0]  vl,
  input  logic             advance,
  output logic             vec,
  output logic [VL_W-1:0]  eff_idx,
  output logic             exhausted,
  output logic [IDX_W-1:0] reg_idx
);
  logic [VL_W-1:0]  idx_q, idx_d;
  logic             vec_q, vec_d;
  logic [MAXVL-1:0] mask_q, mask_d;
  logic [IDX_W-1:0] base_q, base_d;
  logic             en;
  logic             found;
  logic [VL_W-1:0]  hit;

  // lowest enabled element at or above the current index and below vl
  always_comb begin
    found = 1'b0;
    hit   = '0;
    for (int k = 0; k < MAXVL; k++) begin
      if (!found && mask_q[k] && (VL_W'(k) >= idx_q) && (VL_W'(k) < vl)) begin
        found = 1'b1;
        hit   = VL_W'(k);
      end
    end
  end

  assign vec       = vec_q;
  assign eff_idx   = vec_q ? (found ? hit : vl) : '0;
  assign exhausted = vec_q ? !found : (vl == '0);
  assign reg_idx   = base_q + IDX_W'(eff_idx);

  assign en = load | advance;

  always_comb begin
    idx_d  = idx_q;
    vec_d  = vec_q;
    mask_d = mask_q;
    base_d = base_q;
    if (load) begin
      idx_d  = '0;
      vec_d  = cfg_vec;
      mask_d = cfg_mask;
      base_d = cfg_base;
    end else if (advance && vec_q) begin
      idx_d = eff_idx + VL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      vec_q  <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
    end else if (en) begin
      idx_q  <= idx_d;
      vec_q  <= vec_d;
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  // R2/R3: a chosen vector element lies in [index, vl) and its mask bit is set
  p_skip_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_q && !exhausted) |->
      (eff_idx >= idx_q) && (eff_idx < vl) && (|((mask_q >> eff_idx) & MAXVL'(1))));

  // R3: a scalar side points at its base register
  p_scalar_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_q |-> (reg_idx == base_q));
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover #(
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int VL_W  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] src_base,
  input  logic [IDX_W-1:0] dst_base,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic             src_pred_en,
  input  logic             dst_pred_en,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic [VL_W-1:0]  vl,
  output logic             busy,
  output logic             mv_valid,
  input  logic             mv_ready,
  output logic [IDX_W-1:0] mv_src,
  output logic [IDX_W-1:0] mv_dst,
  output logic             done
);
  import pmv_pkg::*;

  pmv_state_e       state_q, state_d;
  logic [VL_W-1:0]  vl_q, vl_d;
  logic             fin_q, fin_d;
  logic             load, xfer, end_c, st_en;
  logic             s_vec, d_vec, s_exh, d_exh;
  logic [VL_W-1:0]  s_eff, d_eff;
  logic [MAXVL-1:0] s_mask_eff, d_mask_eff;

  assign load       = (state_q == PMV_IDLE) && start;
  assign s_mask_eff = src_pred_en ? src_mask : '1;
  assign d_mask_eff = dst_pred_en ? dst_mask : '1;

  pmv_lane #(.NREG(NREG), .MAXVL(MAXVL)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_vec(src_vec),
    .cfg_mask(s_mask_eff), .cfg_base(src_base), .vl(vl_q), .advance(xfer),
    .vec(s_vec), .eff_idx(s_eff), .exhausted(s_exh), .reg_idx(mv_src));

  pmv_lane #(.NREG(NREG), .MAXVL(MAXVL)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_vec(dst_vec),
    .cfg_mask(d_mask_eff), .cfg_base(dst_base), .vl(vl_q), .advance(xfer),
    .vec(d_vec), .eff_idx(d_eff), .exhausted(d_exh), .reg_idx(mv_dst));

  assign end_c    = fin_q | s_exh | d_exh;
  assign busy     = (state_q == PMV_RUN);
  assign mv_valid = busy && !end_c;
  assign done     = busy && end_c;
  assign xfer     = mv_valid && mv_ready;
  assign st_en    = load | done | xfer;

  always_comb begin
    state_d = state_q;
    vl_d    = vl_q;
    fin_d   = fin_q;
    if (load) begin
      state_d = PMV_RUN;
      vl_d    = (vl > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl;
      fin_d   = 1'b0;
    end else if (done) begin
      state_d = PMV_IDLE;
    end else if (xfer && !s_vec && !d_vec) begin
      fin_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PMV_IDLE;
      vl_q    <= '0;
      fin_q   <= 1'b0;
    end else if (st_en) begin
      state_q <= state_d;
      vl_q    <= vl_d;
      fin_q   <= fin_d;
    end
  end

  // R9: a stalled move holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_src) && $stable(mv_dst)));

  // R6: done is a single-cycle pulse that returns to idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R1: busy holds until done
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R7: scalar-to-scalar finishes right after its one move
  p_scalar_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !s_vec && !d_vec) |=> done);

  // R6: no index at or beyond the length is ever presented
  p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> ((s_eff < vl_q) && (d_eff < vl_q)));
endmodule

// File: tb/tb_twin_pred_mover.sv
module tb_twin_pred_mover;
  localparam int NREG  = 16;
  localparam int MAXVL = 8;
  localparam int IDX_W = 4;
  localparam int VL_W  = 4;

  typedef struct packed {
    logic       sv, dv, spe, dpe;
    logic [7:0] sm, dm;
    logic [3:0] vl, sb, db;
    logic [4:0] n;
  } case_t;

  localparam int NC = 16;
  localparam case_t CASES [NC] = '{
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,4'd5, 4'd3, 4'd8,5'd5}, // R3 broadcast
    '{1'b0,1'b1,1'b0,1'b1,8'h00,8'hA6,4'd8, 4'd1, 4'd4,5'd4}, // R3 sparse broadcast
    '{1'b1,1'b0,1'b1,1'b0,8'h10,8'h00,4'd8, 4'd0, 4'd9,5'd1}, // R2 extract
    '{1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,4'd6, 4'd2, 4'd10,5'd6},// R5 copy
    '{1'b1,1'b1,1'b1,1'b0,8'hC9,8'h00,4'd8, 4'd0, 4'd8,5'd4}, // R2 gather
    '{1'b1,1'b1,1'b0,1'b1,8'h00,8'h54,4'd8, 4'd5, 4'd0,5'd3}, // R3 scatter
    '{1'b1,1'b1,1'b1,1'b1,8'hF0,8'h0B,4'd8, 4'd0, 4'd8,5'd3}, // R6 gather+scatter
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd4, 4'd6, 4'd7,5'd1}, // R7 scalar pair
    '{1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,4'd0, 4'd0, 4'd0,5'd0}, // R6 zero length
    '{1'b1,1'b1,1'b1,1'b0,8'hF8,8'h00,4'd3, 4'd0, 4'd0,5'd0}, // R6 mask beyond vl
    '{1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,4'd4, 4'd14,4'd0,5'd4}, // R4 wrap
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd0, 4'd1, 4'd2,5'd0}, // R6 scalar, zero length
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,4'd12,4'd0, 4'd0,5'd8}, // R10 clamp
    '{1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,4'd8, 4'd0, 4'd0,5'd0}, // R6 empty mask
    '{1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,4'd3, 4'd0, 4'd4,5'd3}, // R8 mask ignored
    '{1'b1,1'b0,1'b1,1'b0,8'h06,8'h00,4'd8, 4'd0, 4'd3,5'd2}  // R2 two-bit extract
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [IDX_W-1:0] src_base, dst_base;
  logic             src_vec, dst_vec, src_pred_en, dst_pred_en;
  logic [MAXVL-1:0] src_mask, dst_mask;
  logic [VL_W-1:0]  vl;
  logic             busy, mv_valid, mv_ready, done;
  logic [IDX_W-1:0] mv_src, mv_dst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_n;
  int exp_src [32];
  int exp_dst [32];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twin_pred_mover #(.NREG(NREG), .MAXVL(MAXVL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .src_vec(src_vec), .dst_vec(dst_vec), .src_pred_en(src_pred_en),
    .dst_pred_en(dst_pred_en), .src_mask(src_mask), .dst_mask(dst_mask), .vl(vl),
    .busy(busy), .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_src(mv_src),
    .mv_dst(mv_dst), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected move list, built from the requirements
  task automatic model(input case_t c);
    int vle, i, j;
    logic [7:0] sm, dm;
    vle = (c.vl > 8) ? 8 : int'(c.vl);   // R10
    sm = c.spe ? c.sm : 8'hFF;           // R8
    dm = c.dpe ? c.dm : 8'hFF;
    i = 0; j = 0; exp_n = 0;
    for (int g = 0; g < 20; g++) begin
      if (c.sv) while (i < vle && !sm[i]) i++;
      if (c.dv) while (j < vle && !dm[j]) j++;
      if (c.sv ? (i >= vle) : (vle == 0)) break;
      if (c.dv ? (j >= vle) : (vle == 0)) break;
      exp_src[exp_n] = (int'(c.sb) + i) % NREG;
      exp_dst[exp_n] = (int'(c.db) + j) % NREG;
      exp_n++;
      if (!c.sv && !c.dv) break;
      if (c.sv) i++;
      if (c.dv) j++;
    end
  endtask

  task automatic drive_cfg(input case_t c);
    src_vec = c.sv; dst_vec = c.dv; src_pred_en = c.spe; dst_pred_en = c.dpe;
    src_mask = c.sm; dst_mask = c.dm; vl = c.vl; src_base = c.sb; dst_base = c.db;
  endtask

  task automatic collect(input int pat, input string tag);
    int k = 0;
    bit got_done = 1'b0;
    bit r;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        got_done = 1'b1;
        check(!mv_valid, "R6 valid with done", int'(mv_valid), 0);
        check(k == exp_n, {tag, " move count"}, k, exp_n);
        break;
      end
      r = (pat == 0) ? 1'b1 : ((cyc % 3) != 2);
      if (mv_valid) begin
        if (k < exp_n) begin
          check(int'(mv_src) == exp_src[k], {tag, " R4 src"}, int'(mv_src), exp_src[k]);
          check(int'(mv_dst) == exp_dst[k], {tag, " R4 dst"}, int'(mv_dst), exp_dst[k]);
        end else begin
          check(1'b0, {tag, " R6 extra move"}, k, exp_n);
        end
        if (r) k++;
      end
      mv_ready = r;
    end
    check(got_done, {tag, " R6 done seen (watchdog)"}, int'(got_done), 1);
    @(negedge clk);
    mv_ready = 1'b0;
    check(!done && !busy, {tag, " R6 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mv_ready = 1'b0;
    drive_cfg(CASES[0]);
    repeat (3) @(negedge clk);
    check(!busy && !mv_valid && !done, "R11 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mv_valid && !done, "R11 after reset", int'(busy), 0);

    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < NC; c++) begin
        model(CASES[c]);
        check(exp_n == int'(CASES[c].n), "table count", exp_n, int'(CASES[c].n));
        drive_cfg(CASES[c]);
        start = 1'b1;
        collect(p, $sformatf("case%0d", c));
      end
    end

    // R1: start and config changes while busy are ignored
    begin
      case_t c2;
      model(CASES[0]);
      drive_cfg(CASES[0]);
      start = 1'b1;
      mv_ready = 1'b0;
      @(negedge clk);
      check(busy, "R1 busy after start", int'(busy), 1);
      c2 = CASES[7];
      drive_cfg(c2);
      start = 1'b1;
      @(negedge clk);
      collect(0, "R1 busy start");
    end

    // R9: a long stall keeps the same pair
    begin
      logic [IDX_W-1:0] hs, hd;
      model(CASES[3]);
      drive_cfg(CASES[3]);
      start = 1'b1;
      mv_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      hs = mv_src; hd = mv_dst;
      repeat (4) @(negedge clk);
      check(mv_valid && mv_src == hs && mv_dst == hd, "R9 stall hold",
            int'(mv_src), int'(hs));
      collect(0, "R9 after stall");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule